// File: doc/BRIEF.md
# Packed Half-Precision to Normalized Integer Converter

The block turns a group of 16-bit half-precision floating-point operands into normalized 16-bit integers and packs the results into one output word. A single mode input selects the target range. In signed-normalized mode, +1.0 maps to +32767 and -1.0 maps to -32767. In unsigned-normalized mode, 0.0 maps to 0 and 1.0 maps to 65535.

Each lane scales its operand by the full-scale value of the selected mode and rounds the exact product to the nearest integer, with ties going to even. It then clamps the rounded value into the legal range. Subnormal inputs keep their exact value. Infinities saturate, and NaN yields zero.

The conversion itself is combinational. A parameter either adds one output register stage, with a valid flag that travels beside the data, or passes the result straight through. A shader or texture-store datapath uses the block to pack two half-precision values into one 32-bit word.

Top module: `hnorm_pack`

## Requirements
- R1: With `in_snorm`=1, each lane outputs the two's-complement value round-to-nearest-even(x × 32767), where x is the exact value of the half operand.
- R2: With `in_snorm`=0, each lane outputs the unsigned value round-to-nearest-even(x × 65535), where x is the exact value of the half operand.
- R3: A NaN operand (exponent field all ones, mantissa field nonzero) gives a lane result of 0 in both modes.
- R4: In signed mode, the result is clamped to -32767..+32767. The result is never 0x8000. +infinity gives 0x7FFF and -infinity gives 0x8001.
- R5: In unsigned mode, the result is clamped to 0..65535. Every negative operand, including -infinity, gives 0, and +infinity gives 0xFFFF.
- R6: The result of lane i occupies bits 16i+15 down to 16i of `out_word`. Lane i takes its operand from the same bit positions of `in_src`, so the first operand lands in bits 15:0.
- R7: Subnormal operands (exponent field zero) are converted at their exact value, 2^-24 × mantissa, and are not flushed to zero.
- R8: +0 and -0 both convert to 0 in both modes.
- R9: With `REG_OUT`=1, `out_valid` equals `in_valid` one clock later. The output word loads only in a cycle where `in_valid` is high and otherwise holds its value.
- R10: With `REG_OUT`=0, `out_valid` and `out_word` follow `in_valid` and `in_src` in the same cycle, with no clock.
- R11: With `REG_OUT`=1, a low `rst_n` sampled at a rising clock edge clears `out_valid` and `out_word` to 0, whatever `in_valid` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand word is valid this cycle |
| in_snorm | input | 1 | 1 selects signed-normalized, 0 selects unsigned-normalized |
| in_src | input | 16×LANES | Packed half-precision operands, lane 0 in the low bits |
| out_valid | output | 1 | Result word is valid |
| out_word | output | 16×LANES | Packed normalized integer results |

## Verification
The bench builds two copies of the block with the default two lanes: one with `REG_OUT`=1 and one with `REG_OUT`=0. Every stimulus is checked against both, which reaches the one-cycle latency, the hold on an idle cycle and the reset clear, as well as the same-cycle pass-through. Because there are two lanes, a swap of the lanes or a mismatch between them shows up in the packed word. Directed operands cover the exact ties at 0.5, ±1.0, both infinities, NaN, both zeros and the smallest and largest subnormals. The random operands are biased toward exponents below the bias, so that the rounding path carries most of them.

// File: rtl/hnorm_pkg.sv
// Package: shared constants and the decoded-operand record for the
// half-precision to normalized-integer converter.
// Assumes IEEE binary16 inputs and 16-bit integer results.
package hnorm_pkg;
    localparam int HALF_W   = 16;
    localparam int EXP_W    = 5;
    localparam int MAN_W    = 10;
    localparam int OUT_W    = 16;
    localparam int SIG_W    = MAN_W + 1;
    localparam int PROD_W   = SIG_W + OUT_W;
    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
    localparam int SHIFT_W  = $clog2(MAN_W + BIAS + 1);
    localparam logic [OUT_W-1:0] SNORM_FULL = OUT_W'((1 << (OUT_W - 1)) - 1);
    localparam logic [OUT_W-1:0] UNORM_FULL = '1;

    // Decoded operand: sign, class flags and the significand with its
    // effective exponent (value = sig * 2^(exp_eff - BIAS - MAN_W)).
    typedef struct packed {
        logic               sign;
        logic               is_nan;
        logic               is_big;
        logic [SIG_W-1:0]   sig;
        logic [EXP_W-1:0]   exp_eff;
    } hnorm_op_t;
endpackage

// File: rtl/hnorm_decode.sv
// Module: hnorm_decode
// Splits one half-precision word into sign, significand and effective
// exponent, and classifies NaN and magnitudes of at least 1.0.
// Assumes: subnormals use exponent 1 with no hidden bit (exact value).
module hnorm_decode
    import hnorm_pkg::*;
(
    input  logic [HALF_W-1:0] half_in,
    output hnorm_op_t         op_out
);
    logic [EXP_W-1:0] exp_fld;
    logic [MAN_W-1:0] man_fld;
    logic             exp_zero;

    assign exp_fld  = half_in[MAN_W +: EXP_W];
    assign man_fld  = half_in[MAN_W-1:0];
    assign exp_zero = (exp_fld == '0);

    // Build the decoded record from the raw fields.
    always_comb begin
        op_out.sign    = half_in[HALF_W-1];
        op_out.is_nan  = (&exp_fld) && (|man_fld);
        op_out.is_big  = (exp_fld >= EXP_W'(BIAS));
        op_out.sig     = {~exp_zero, man_fld};
        op_out.exp_eff = exp_zero ? EXP_W'(1) : exp_fld;
    end
endmodule

// File: rtl/hnorm_quant.sv
// Module: hnorm_quant
// Scales one decoded operand by the full-scale value of the selected
// mode, rounds the exact fixed-point product to nearest-even, then
// clamps and applies the sign. NaN gives zero.
// Assumes: operands with is_big clear have magnitude below 1.0, so the
// right shift lies between MAN_W+1 and MAN_W+BIAS-1.
module hnorm_quant
    import hnorm_pkg::*;
(
    input  hnorm_op_t        op_in,
    input  logic             snorm,
    output logic [OUT_W-1:0] result
);
    logic [OUT_W-1:0]   full_scale;
    logic [SHIFT_W-1:0] shamt;
    logic [PROD_W-1:0]  product;
    logic [PROD_W-1:0]  quot;
    logic [PROD_W-1:0]  rem_mask;
    logic [PROD_W-1:0]  remainder;
    logic [PROD_W-1:0]  half_lsb;
    logic               round_up;
    logic [PROD_W-1:0]  rounded;
    logic [OUT_W-1:0]   magnitude;

    assign full_scale = snorm ? SNORM_FULL : UNORM_FULL;
    assign shamt      = SHIFT_W'(MAN_W + BIAS) - SHIFT_W'(op_in.exp_eff);

    // Exact product and its split into integer part and discarded bits.
    always_comb begin
        product   = PROD_W'(op_in.sig) * PROD_W'(full_scale);
        quot      = product >> shamt;
        rem_mask  = (PROD_W'(1) << shamt) - PROD_W'(1);
        remainder = product & rem_mask;
        half_lsb  = PROD_W'(1) << (shamt - SHIFT_W'(1));
    end

    // Round to nearest, ties to even.
    always_comb begin
        round_up = (remainder > half_lsb) || ((remainder == half_lsb) && quot[0]);
        rounded  = quot + PROD_W'(round_up);
    end

    // Saturate large magnitudes, apply the sign per mode, force NaN to zero.
    always_comb begin
        magnitude = op_in.is_big ? full_scale : rounded[OUT_W-1:0];
        if (op_in.is_nan)
            result = '0;
        else if (!op_in.sign)
            result = magnitude;
        else if (snorm)
            result = OUT_W'(0) - magnitude;
        else
            result = '0;
    end

    // Guard the rounding path and the signed range.
    always_comb begin
        if (!op_in.is_big && !op_in.is_nan)
            a_r1_round_in_range: assert (rounded <= PROD_W'(full_scale))
                else $error("rounded magnitude exceeds full scale");
        if (snorm)
            a_r4_no_most_negative: assert (result != {1'b1, {(OUT_W-1){1'b0}}})
                else $error("signed result hit the most negative code");
    end
endmodule

// File: rtl/hnorm_pack.sv
// Module: hnorm_pack (top)
// Converts LANES half-precision operands to normalized 16-bit integers
// (signed or unsigned by in_snorm) and packs them, lane 0 lowest.
// REG_OUT=1 adds one output register with a valid flag; REG_OUT=0 is
// purely combinational. Reset is synchronous and active low.
module hnorm_pack
    import hnorm_pkg::*;
#(
    parameter int LANES   = 2,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_snorm,
    input  logic [LANES*HALF_W-1:0]  in_src,
    output logic                     out_valid,
    output logic [LANES*OUT_W-1:0]   out_word
);
    localparam int WORD_W = LANES * OUT_W;

    logic [WORD_W-1:0] comb_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hnorm_op_t lane_op;

        hnorm_decode u_dec (
            .half_in (in_src[g*HALF_W +: HALF_W]),
            .op_out  (lane_op)
        );

        hnorm_quant u_quant (
            .op_in  (lane_op),
            .snorm  (in_snorm),
            .result (comb_word[g*OUT_W +: OUT_W])
        );
    end

    if (REG_OUT) begin : g_reg
        logic              valid_q;
        logic [WORD_W-1:0] word_q;

        // Output stage: valid follows input, data loads only on valid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                word_q  <= '0;
            end else begin
                valid_q <= in_valid;
                if (in_valid)
                    word_q <= comb_word;
            end
        end

        assign out_valid = valid_q;
        assign out_word  = word_q;

        a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (out_valid == $past(in_valid)))
            else $error("out_valid does not follow in_valid by one cycle");

        a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(in_valid)) |-> $stable(out_word))
            else $error("out_word changed without in_valid");

        a_r11_reset_clears: assert property (@(posedge clk) disable iff (1'b0)
            !rst_n |=> (!out_valid && (out_word == '0)))
            else $error("reset did not clear the output stage");
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_word  = comb_word;
    end
endmodule

// File: tb/hnorm_pack_tb.sv
`timescale 1ns/1ps
module hnorm_pack_tb;
    localparam int LANES = 2;
    localparam int W     = 16 * LANES;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_snorm = 1'b0;
    logic [W-1:0] in_src = '0;
    logic         ov_r, ov_c;
    logic [W-1:0] ow_r, ow_c;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hnorm_pack #(.LANES(LANES), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_snorm(in_snorm),
        .in_src(in_src), .out_valid(ov_r), .out_word(ow_r));

    hnorm_pack #(.LANES(LANES), .REG_OUT(1'b0)) u_dut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_snorm(in_snorm),
        .in_src(in_src), .out_valid(ov_c), .out_word(ow_c));

    // Reference for one lane, from the requirements in real arithmetic.
    function automatic logic [15:0] ref_lane(input logic [15:0] h, input logic sn);
        int  e = int'(h[14:10]);
        int  f = int'(h[9:0]);
        real v, x, r, hi, lo;
        int  iv;
        if (e == 31 && f != 0) return 16'h0000;              // R3
        if (e == 31)      v = 1.0e6;
        else if (e == 0)  v = f * (2.0 ** (-24));              // R7
        else              v = (1024 + f) * (2.0 ** (e - 25));
        x = v * (sn ? 32767.0 : 65535.0);
        r = $floor(x);
        if (x - r > 0.5) r = r + 1.0;
        else if (x - r == 0.5 && (r - 2.0 * $floor(r / 2.0)) == 1.0) r = r + 1.0;
        if (h[15]) r = -r;
        hi = sn ? 32767.0 : 65535.0;
        lo = sn ? -32767.0 : 0.0;
        if (r > hi) r = hi;
        if (r < lo) r = lo;
        iv = $rtoi(r);
        return iv[15:0];
    endfunction

    function automatic logic [W-1:0] ref_word(input logic [W-1:0] s, input logic sn);
        logic [W-1:0] w;
        for (int i = 0; i < LANES; i++) w[i*16 +: 16] = ref_lane(s[i*16 +: 16], sn);
        return w;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operand word and check both variants at their cycle.
    task automatic apply(input logic [W-1:0] s, input logic sn, input string tag);
        logic [W-1:0] exp;
        exp = ref_word(s, sn);
        @(negedge clk);
        in_src = s; in_snorm = sn; in_valid = 1'b1;
        #2;
        check(ow_c == exp, {tag, " R10 comb word"}, ow_c, exp);
        check(ov_c == 1'b1, "R10 comb valid", W'(ov_c), W'(1));
        @(posedge clk);
        #2;
        check(ow_r == exp, {tag, " reg word"}, ow_r, exp);
        check(ov_r == 1'b1, "R9 reg valid", W'(ov_r), W'(1));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [W-1:0] held;
        void'($urandom(32'd20240611));

        // R11: reset clears the registered stage even with in_valid high.
        in_valid = 1'b1; in_src = 32'h3C00_3C00; in_snorm = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check(ov_r == 1'b0, "R11 valid in reset", W'(ov_r), W'(0));
        check(ow_r == '0, "R11 word in reset", ow_r, '0);
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b1;

        // Directed corners (low lane first operand).
        apply(32'h3800_3800, 1'b1, "R1 tie 0.5 snorm");      // 16384
        apply(32'h3800_3800, 1'b0, "R2 tie 0.5 unorm");      // 32768
        apply(32'hBC00_3C00, 1'b1, "R4 +-1.0 snorm");        // 8001_7FFF
        apply(32'hFC00_7C00, 1'b1, "R4 +-inf snorm");
        apply(32'hFC00_7C00, 1'b0, "R5 +-inf unorm");
        apply(32'hB800_C000, 1'b0, "R5 negative unorm");
        apply(32'h7E00_FE01, 1'b1, "R3 NaN snorm");
        apply(32'h7C01_7E00, 1'b0, "R3 NaN unorm");
        apply(32'h8000_0000, 1'b1, "R8 zeros snorm");
        apply(32'h8000_0000, 1'b0, "R8 zeros unorm");
        apply(32'h03FF_0001, 1'b0, "R7 subnormal unorm");
        apply(32'h83FF_0200, 1'b1, "R7 subnormal snorm");
        apply(32'h3C00_0000, 1'b0, "R6 lane order");
        check(ow_r == 32'hFFFF_0000, "R6 lane order literal", ow_r, 32'hFFFF_0000);
        apply(32'h7BFF_3BFF, 1'b1, "R4 large finite snorm");

        // R9: idle cycle holds the word and drops valid.
        held = ow_r;
        @(negedge clk);
        in_valid = 1'b0; in_src = 32'h3555_2AAA;
        @(posedge clk);
        #2;
        check(ow_r == held, "R9 hold word", ow_r, held);
        check(ov_r == 1'b0, "R9 valid low", W'(ov_r), W'(0));
        check(ov_c == 1'b0, "R10 comb valid low", W'(ov_c), W'(0));

        // Random operands, biased toward magnitudes below one.
        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] s;
            s = W'($urandom);
            if (i % 3 != 0) begin
                for (int l = 0; l < LANES; l++)
                    s[l*16 + 10 +: 5] = 5'($urandom_range(0, 15));
            end
            apply(s, 1'($urandom), (i % 2 == 0) ? "R1 random" : "R2 random");
        end

        // R11: mid-run reset clears again.
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1;
        @(posedge clk);
        #2;
        check(ov_r == 1'b0 && ow_r == '0, "R11 mid-run reset", ow_r, '0);

        finish_run();
    end
endmodule